// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 32-bit integer arithmetic unit that can split its operands into independent lanes. A 2-bit lane-mode input picks one 32-bit lane, four 8-bit lanes or two 16-bit lanes. Each operation then runs separately in every lane. No carry, borrow, saturation clamp or halving shift ever crosses a lane boundary. The operations are:

- wrapping add and subtract
- saturating add and subtract, signed and unsigned
- halving add and subtract, signed and unsigned
- min and max, signed and unsigned
- six compare-to-mask operations
- a bitwise select

The select operation reads a third operand: the old destination value. For select, the same 2-bit field does not choose a lane width. It chooses one of four operand-order variants.

The datapath is combinational and ends in a single output register. A result therefore appears on the clock edge after its operands are presented, and a new operation can be issued every cycle. The lane mode 11 is reserved. Using it with an arithmetic operation, or using an undefined operation code, raises an illegal flag and forces the result to zero.

Top module: `simd_alu`

## Requirements
- R1: A synchronous active-high reset clears `result_o` and `illegal_o` to zero. Outside reset, `result_o` and `illegal_o` show the outcome of the inputs sampled at the previous rising clock edge.
- R2: Lane mode 00 is one 32-bit lane, 01 is four 8-bit lanes (lane k occupies bits 8k+7:8k), and 10 is two 16-bit lanes (lane k occupies bits 16k+15:16k). Operation codes (decimal) are: ADD 0, SUB 1, ADDS 2, ADDSU 3, SUBS 4, SUBSU 5, ADDH 6, ADDHU 7, SUBH 8, SUBHU 9, MIN 10, MAX 11, MINU 12, MAXU 13, SEQ 14, SNE 15, SLT 16, SLTU 17, SLE 18, SLEU 19, SEL 20.
- R3: ADD and SUB wrap modulo 2^lane-width in each lane, with no carry or borrow passed to the neighbouring lane.
- R4: ADDS and SUBS treat lanes as signed. A result above the lane's largest signed value is clamped to that value, and a result below the smallest is clamped to the smallest.
- R5: ADDSU clamps an unsigned lane overflow to all ones. SUBSU clamps an unsigned lane underflow to zero.
- R6: ADDH/SUBH (signed) and ADDHU/SUBHU (unsigned operands) return floor((a op b)/2), computed at full precision, for each lane. A negative difference from SUBHU is kept as its two's-complement lane value.
- R7: SEQ, SNE, SLT (signed), SLTU, SLE (signed) and SLEU write all ones to a lane when a op b holds in that lane, and all zeros otherwise.
- R8: MIN/MAX compare lanes as signed values, and MINU/MAXU compare them as unsigned values. Each lane returns the smaller or larger operand.
- R9: SEL uses the mode field as a variant, with c = `c_i`: 00 gives (a&c)|(b&~c), 01 gives (b&c)|(a&~c), 10 gives (c&a)|(b&~a), 11 gives (b&a)|(c&~a). SEL never raises `illegal_o`.
- R10: `illegal_o` is 1, and `result_o` is zero, when the operation code is above 20, or when the mode is 11 with any operation other than SEL. Otherwise `illegal_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| mode_i | input | 2 | Lane mode, or select variant for SEL |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| c_i | input | 32 | Old destination value, used by SEL |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered illegal mode/operation flag |

## Verification
The in-design assertions check several properties on every cycle:

- An illegal flag always comes with a zero result.
- A legal code and mode never raise the flag.
- Every byte-lane compare result consists of whole 00 or FF bytes.
- A signed word add of two non-negative operands never turns negative.
- An unsigned saturating word add never returns less than its first operand.

Exact lane values need the bench's sweeps. These include carry isolation at lane edges, the exact clamp values, floor rounding of negative halves and the four select operand orders. The sweeps drive every legal operation and mode over a table of boundary words and over random words, and compare the results against integer arithmetic done per lane in the bench.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_ADDS  = 5'd2,
    OP_ADDSU = 5'd3,
    OP_SUBS  = 5'd4,
    OP_SUBSU = 5'd5,
    OP_ADDH  = 5'd6,
    OP_ADDHU = 5'd7,
    OP_SUBH  = 5'd8,
    OP_SUBHU = 5'd9,
    OP_MIN   = 5'd10,
    OP_MAX   = 5'd11,
    OP_MINU  = 5'd12,
    OP_MAXU  = 5'd13,
    OP_SEQ   = 5'd14,
    OP_SNE   = 5'd15,
    OP_SLT   = 5'd16,
    OP_SLTU  = 5'd17,
    OP_SLE   = 5'd18,
    OP_SLEU  = 5'd19,
    OP_SEL   = 5'd20
  } alu_op_e;

  localparam logic [1:0] MODE_WORD    = 2'b00;
  localparam logic [1:0] MODE_QUARTER = 2'b01;
  localparam logic [1:0] MODE_HALF    = 2'b10;
  localparam logic [1:0] MODE_RSVD    = 2'b11;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W:0] s_sum, s_dif, u_sum, u_dif;
  logic       eq, slt, ult;

  always_comb begin
    s_sum = {a[W-1], a} + {b[W-1], b};
    s_dif = {a[W-1], a} - {b[W-1], b};
    u_sum = {1'b0, a} + {1'b0, b};
    u_dif = {1'b0, a} - {1'b0, b};
    eq    = (a == b);
    slt   = ($signed(a) < $signed(b));
    ult   = (a < b);
  end

  always_comb begin
    case (op)
      OP_ADD:   y = u_sum[W-1:0];
      OP_SUB:   y = u_dif[W-1:0];
      OP_ADDS:  y = (s_sum[W] != s_sum[W-1]) ? (s_sum[W] ? SMIN : SMAX) : s_sum[W-1:0];
      OP_SUBS:  y = (s_dif[W] != s_dif[W-1]) ? (s_dif[W] ? SMIN : SMAX) : s_dif[W-1:0];
      OP_ADDSU: y = u_sum[W] ? ONES : u_sum[W-1:0];
      OP_SUBSU: y = u_dif[W] ? '0 : u_dif[W-1:0];
      OP_ADDH:  y = s_sum[W:1];
      OP_ADDHU: y = u_sum[W:1];
      OP_SUBH:  y = s_dif[W:1];
      OP_SUBHU: y = u_dif[W:1];
      OP_MIN:   y = slt ? a : b;
      OP_MAX:   y = slt ? b : a;
      OP_MINU:  y = ult ? a : b;
      OP_MAXU:  y = ult ? b : a;
      OP_SEQ:   y = {W{eq}};
      OP_SNE:   y = {W{~eq}};
      OP_SLT:   y = {W{slt}};
      OP_SLTU:  y = {W{ult}};
      OP_SLE:   y = {W{slt | eq}};
      OP_SLEU:  y = {W{ult | eq}};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/simd_select.sv
module simd_select #(
  parameter int W = 32
) (
  input  logic [1:0]   variant,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);

  always_comb begin
    case (variant)
      2'b00:   y = (a & c) | (b & ~c);
      2'b01:   y = (b & c) | (a & ~c);
      2'b10:   y = (c & a) | (b & ~a);
      default: y = (b & a) | (c & ~a);
    endcase
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);

  localparam int Q_W    = DATA_W / 4;
  localparam int H_W    = DATA_W / 2;
  localparam int Q_LANES = 4;
  localparam int H_LANES = 2;

  alu_op_e           op;
  logic              op_known, is_sel, bad;
  logic [DATA_W-1:0] word_y, quarter_y, half_y, sel_y, arith_y, next_y;

  assign op       = alu_op_e'(op_i);
  assign op_known = (op_i <= 5'(OP_SEL));
  assign is_sel   = (op_i == 5'(OP_SEL));
  assign bad      = !op_known || (!is_sel && mode_i == MODE_RSVD);

  simd_lane #(.W(DATA_W)) u_word (
    .op (op),
    .a  (a_i),
    .b  (b_i),
    .y  (word_y)
  );

  for (genvar g = 0; g < Q_LANES; g++) begin : g_quarter
    simd_lane #(.W(Q_W)) u_lane (
      .op (op),
      .a  (a_i[g*Q_W +: Q_W]),
      .b  (b_i[g*Q_W +: Q_W]),
      .y  (quarter_y[g*Q_W +: Q_W])
    );
  end

  for (genvar g = 0; g < H_LANES; g++) begin : g_half
    simd_lane #(.W(H_W)) u_lane (
      .op (op),
      .a  (a_i[g*H_W +: H_W]),
      .b  (b_i[g*H_W +: H_W]),
      .y  (half_y[g*H_W +: H_W])
    );
  end

  simd_select #(.W(DATA_W)) u_select (
    .variant (mode_i),
    .a       (a_i),
    .b       (b_i),
    .c       (c_i),
    .y       (sel_y)
  );

  always_comb begin
    case (mode_i)
      MODE_WORD:    arith_y = word_y;
      MODE_QUARTER: arith_y = quarter_y;
      MODE_HALF:    arith_y = half_y;
      default:      arith_y = '0;
    endcase
    if (bad)         next_y = '0;
    else if (is_sel) next_y = sel_y;
    else             next_y = arith_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= next_y;
      illegal_o <= bad;
    end
  end

  function automatic logic quarters_are_masks(logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < Q_LANES; k++) begin
      if (v[k*Q_W +: Q_W] != '0 && v[k*Q_W +: Q_W] != {Q_W{1'b1}}) ok = 1'b0;
    end
    return ok;
  endfunction

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0));

  // R10
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_RSVD && op_i <= 5'(OP_SEL)) |=> !illegal_o);

  // R7
  mask_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 5'(OP_SEQ) && op_i <= 5'(OP_SLEU) && mode_i == MODE_QUARTER)
      |=> quarters_are_masks(result_o));

  // R4
  sat_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_ADDS) && mode_i == MODE_WORD && !a_i[DATA_W-1] && !b_i[DATA_W-1])
      |=> !result_o[DATA_W-1]);

  // R5
  satu_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'(OP_ADDSU) && mode_i == MODE_WORD) |=> (result_o >= $past(a_i)));

endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_i;
  logic [1:0]  mode_i;
  logic [31:0] a_i, b_i, c_i;
  logic [31:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  simd_alu i_simd_alu (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .mode_i    (mode_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
  );

  function automatic string req_of(int op);
    if (op > 20) return "R10";
    if (op <= 1) return "R3";
    if (op == 2 || op == 4) return "R4";
    if (op == 3 || op == 5) return "R5";
    if (op <= 9) return "R6";
    if (op <= 13) return "R8";
    if (op <= 19) return "R7";
    return "R9";
  endfunction

  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic longint lane_ref(int op, int w, longint ua, longint ub);
    longint m, h, sa, sb, r;
    m  = (64'sd1 << w) - 1;
    h  = 64'sd1 << (w - 1);
    sa = (ua >= h) ? ua - (m + 1) : ua;
    sb = (ub >= h) ? ub - (m + 1) : ub;
    case (op)
      0:  r = ua + ub;
      1:  r = ua - ub;
      2:  r = clamp(sa + sb, -h, h - 1);
      3:  r = clamp(ua + ub, 0, m);
      4:  r = clamp(sa - sb, -h, h - 1);
      5:  r = clamp(ua - ub, 0, m);
      6:  r = (sa + sb) >>> 1;
      7:  r = (ua + ub) >>> 1;
      8:  r = (sa - sb) >>> 1;
      9:  r = (ua - ub) >>> 1;
      10: r = (sa < sb) ? ua : ub;
      11: r = (sa < sb) ? ub : ua;
      12: r = (ua < ub) ? ua : ub;
      13: r = (ua < ub) ? ub : ua;
      14: r = (ua == ub) ? m : 0;
      15: r = (ua != ub) ? m : 0;
      16: r = (sa < sb) ? m : 0;
      17: r = (ua < ub) ? m : 0;
      18: r = (sa <= sb) ? m : 0;
      19: r = (ua <= ub) ? m : 0;
      default: r = 0;
    endcase
    return r & m;
  endfunction

  function automatic logic [31:0] word_ref(int op, int md, logic [31:0] a, logic [31:0] b,
                                           logic [31:0] c);
    int w;
    longint m, acc;
    if (op > 20) return 32'h0;
    if (op == 20) begin
      case (md)
        0: return (a & c) | (b & ~c);
        1: return (b & c) | (a & ~c);
        2: return (c & a) | (b & ~a);
        default: return (b & a) | (c & ~a);
      endcase
    end
    if (md == 3) return 32'h0;
    w   = (md == 0) ? 32 : (md == 1) ? 8 : 16;
    m   = (64'sd1 << w) - 1;
    acc = 0;
    for (int k = 0; k < 32 / w; k++) begin
      acc = acc | (lane_ref(op, w, (longint'(a) >> (k * w)) & m,
                                   (longint'(b) >> (k * w)) & m) << (k * w));
    end
    return acc[31:0];
  endfunction

  task automatic apply(int op, int md, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] exp;
    logic        exp_ill;
    op_i   = op[4:0];
    mode_i = md[1:0];
    a_i    = a;
    b_i    = b;
    c_i    = c;
    exp     = word_ref(op, md, a, b, c);
    exp_ill = (op > 20) || (md == 3 && op != 20);
    @(negedge clk);
    checks++;
    if (result_o !== exp) begin
      fails++;
      $display("FAIL %s op=%0d mode=%0d a=%h b=%h c=%h result actual=%h expected=%h",
               req_of(op), op, md, a, b, c, result_o, exp);
    end
    checks++;
    if (illegal_o !== exp_ill) begin
      fails++;
      $display("FAIL R10 op=%0d mode=%0d illegal actual=%b expected=%b",
               op, md, illegal_o, exp_ill);
    end
  endtask

  logic [31:0] tbl [8];

  initial begin
    tbl[0] = 32'h0000_0000; tbl[1] = 32'h0000_0001;
    tbl[2] = 32'h7FFF_FFFF; tbl[3] = 32'h8000_0000;
    tbl[4] = 32'hFFFF_FFFF; tbl[5] = 32'h7FFF_8001;
    tbl[6] = 32'h807F_7F80; tbl[7] = 32'h00FF_00FF;

    // R1: reset clears outputs even with an illegal request presented
    rst = 1'b1; op_i = 5'd0; mode_i = 2'b11; a_i = 32'h1234_5678; b_i = 32'h1; c_i = '0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || illegal_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset actual=%h/%b expected=00000000/0", result_o, illegal_o);
    end
    rst = 1'b0;

    // R1: one-cycle latency, R3: carry stays in its byte lane
    apply(0, 1, 32'h00FF_00FF, 32'h0001_0001, 32'h0);
    // R2: same operands in half-word mode carry into bit 8
    apply(0, 2, 32'h00FF_00FF, 32'h0001_0001, 32'h0);

    // R3..R9: boundary table over every legal operation and mode (R2 mode map)
    for (int op = 0; op <= 20; op++) begin
      for (int md = 0; md < ((op == 20) ? 4 : 3); md++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            apply(op, md, tbl[i], tbl[j], tbl[(i + j) % 8] ^ 32'h0F0F_3C3C);
          end
        end
        for (int r = 0; r < 40; r++) begin
          apply(op, md, $urandom, $urandom, $urandom);
        end
      end
    end

    // R10: reserved mode on arithmetic operations, and undefined codes
    for (int op = 0; op < 20; op++) apply(op, 3, $urandom, $urandom, $urandom);
    for (int op = 21; op < 32; op++) apply(op, op % 3, $urandom, $urandom, $urandom);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule